// File: doc/BRIEF.md
# Shared Slave Ownership Guard

This block sits in the path between a system interconnect and one shared slave, for example an SRAM or an accelerator. Each bus request carries a domain ID that names the virtual machine or bus master behind it. A domain must first take ownership of the slave through a small control window. After that, only that domain's data accesses reach the slave. Accesses from any other domain, or accesses made while nobody owns the slave, never reach it. They complete with an error, return zero, and raise a level-sensitive violation interrupt. The interrupt also records the offending domain and address.

When the owner gives the slave up, the guard drives the slave's reset for a fixed number of cycles (parameter `RST_CYCLES`, default 4). Only after that can any domain take the slave again. The reset is applied on every release, even when the same domain takes the slave back, so no state is carried from one tenure to the next.

Ownership is held by a three-state machine:
- `ST_FREE` moves to `ST_OWNED` when a lock request is granted.
- `ST_OWNED` moves to `ST_RESET` on a valid release.
- `ST_RESET` counts down and returns to `ST_FREE`.

A request with `req_addr[ADDR_W-1]=1` targets the control window, and `req_addr[2:0]` selects the register:
- 0: lock. A read is an acquire attempt.
- 1: release. Written by the owner.
- 2: status.
- 3: violation. Bit 0 is write-one-to-clear.
- 4: captured address.

Control accesses are open to every domain. Every request is answered one cycle later on `rsp_*`.

Top module: `pguard_top`

## Requirements
- R1: After reset the status reads free (0) with owner 0, `irq_viol` is low, `slv_rst` is low and `slv_valid` is low.
- R2: A read of the lock register (index 0) while free returns `rdata=1`, and the requester becomes owner. Status then reads `{owner at bits [8+:DID_W], 2'd1 at bits [1:0]}`.
- R3: A lock read while owned or resetting returns 0 with no error. It leaves the owner unchanged and is not queued.
- R4: A data access by the owner is forwarded to the slave in the same cycle. Its response one cycle later has `err=0`, and for reads it carries the slave data. Writes return `rdata=0`.
- R5: A data access by a non-owner, or any data access while free or resetting, is not forwarded. It responds with `err=1` and `rdata=0`, and it sets `irq_viol`.
- R6: `irq_viol` stays high until a write to the violation register (index 3) with bit 0 set. Writing 0 does not clear it. A violation read returns the pending flag at bit 0.
- R7: The violation register keeps the first offender's domain ID at bits [8+:DID_W], and the address register (index 4) keeps its address. Later violations while the flag is pending do not overwrite them, and the fields survive a clear.
- R8: A write to the release register (index 1) by a non-owner responds `err=1` and changes nothing. The owner's release responds `err=0`.
- R9: After a valid release, `slv_rst` is high for exactly `RST_CYCLES` cycles. During that time status reads 2 with owner 0, and afterwards status reads free.
- R10: When a domain releases and relocks, the slave reset is still applied for the full `RST_CYCLES`.
- R11: After the reset completes, a different domain can lock. Its reads and writes then complete normally, and it sees slave contents wiped by the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address; MSB selects control window |
| req_did | input | DID_W | Domain ID of the requester |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Read data |
| slv_valid | output | 1 | Forwarded access to the slave |
| slv_write | output | 1 | Forwarded write strobe |
| slv_addr | output | ADDR_W-1 | Forwarded address |
| slv_wdata | output | DATA_W | Forwarded write data |
| slv_rdata | input | DATA_W | Slave read data, same-cycle |
| slv_rst | output | 1 | Reset to the guarded slave |
| irq_viol | output | 1 | Level violation interrupt |

## Verification
The forwarded slave strobe appears in the same cycle as the request. The response, the owner and status changes, and the interrupt all land one clock edge after the request. The first reset cycle follows the release edge.

The bench drives each request at a falling edge and holds it over one rising edge. It reads the response at the next falling edge, so each result is sampled exactly one register stage after its cause. Back-to-back requests then observe the state left by the previous one.

The reset length is measured by counting falling edges with `slv_rst` high across an idle window longer than `RST_CYCLES`.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_OWNED = 2'd1,
        ST_RESET = 2'd2
    } own_state_e;

    localparam logic [2:0] IDX_LOCK   = 3'd0;
    localparam logic [2:0] IDX_REL    = 3'd1;
    localparam logic [2:0] IDX_STATUS = 3'd2;
    localparam logic [2:0] IDX_VIOL   = 3'd3;
    localparam logic [2:0] IDX_VADDR  = 3'd4;

endpackage

// File: rtl/pguard_fsm.sv
module pguard_fsm
    import pguard_pkg::*;
#(
    parameter int DID_W      = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_req,
    input  logic             rel_req,
    input  logic [DID_W-1:0] req_did,
    output own_state_e       state,
    output logic [DID_W-1:0] owner,
    output logic             grant,
    output logic             rel_ok,
    output logic             slv_rst
);

    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W:0]   RUN_FULL = (CNT_W + 1)'(RST_CYCLES);

    own_state_e       state_n;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   chk_run;

    // state register, owner and countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREE;
            owner <= '0;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (grant) begin
                owner <= req_did;
            end else if (rel_ok) begin
                owner <= '0;
                cnt   <= CNT_LOAD;
            end else if (state == ST_RESET && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        grant   = 1'b0;
        rel_ok  = 1'b0;
        slv_rst = 1'b0;
        state_n = state;
        unique case (state)
            ST_FREE: begin
                grant = lock_req;
                if (lock_req) state_n = ST_OWNED;
            end
            ST_OWNED: begin
                rel_ok = rel_req && (req_did == owner);
                if (rel_ok) state_n = ST_RESET;
            end
            ST_RESET: begin
                slv_rst = 1'b1;
                if (cnt == '0) state_n = ST_FREE;
            end
            default: state_n = ST_FREE;
        endcase
    end

    // checker: length of each slave reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chk_run <= '0;
        else if (slv_rst) chk_run <= chk_run + 1'b1;
        else              chk_run <= '0;
    end

    p_rst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_rst) |-> chk_run == RUN_FULL);

    p_busy_no_steal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req && state != ST_FREE) |=> $stable(owner));

    p_grant_sets_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (state == ST_OWNED && owner == $past(req_did)));

endmodule

// File: rtl/pguard_viol.sv
module pguard_viol #(
    parameter int DID_W  = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [DID_W-1:0]  set_did,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr,
    output logic              irq,
    output logic [DID_W-1:0]  cap_did,
    output logic [ADDR_W-1:0] cap_addr
);

    logic take;

    always_comb take = set && (!irq || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            cap_did  <= '0;
            cap_addr <= '0;
        end else begin
            if (take) begin
                cap_did  <= set_did;
                cap_addr <= set_addr;
            end
            if (set)      irq <= 1'b1;
            else if (clr) irq <= 1'b0;
        end
    end

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    p_capture_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> $stable(cap_did) && $stable(cap_addr));

endmodule

// File: rtl/pguard_top.sv
module pguard_top
    import pguard_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DID_W      = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DID_W-1:0]  req_did,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              slv_valid,
    output logic              slv_write,
    output logic [ADDR_W-2:0] slv_addr,
    output logic [DATA_W-1:0] slv_wdata,
    input  logic [DATA_W-1:0] slv_rdata,
    output logic              slv_rst,
    output logic              irq_viol
);

    localparam int FLD_LO = 8;

    own_state_e        state;
    logic [DID_W-1:0]  owner;
    logic              grant;
    logic              rel_ok;
    logic              is_ctrl;
    logic [2:0]        idx;
    logic              data_ok;
    logic              viol_set;
    logic              lock_req;
    logic              rel_req;
    logic              viol_clr;
    logic [DID_W-1:0]  cap_did;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] rdata_n;
    logic              err_n;

    always_comb begin
        is_ctrl  = req_addr[ADDR_W-1];
        idx      = req_addr[2:0];
        data_ok  = req_valid && !is_ctrl && state == ST_OWNED && req_did == owner;
        viol_set = req_valid && !is_ctrl && !data_ok;
        lock_req = req_valid && is_ctrl && idx == IDX_LOCK && !req_write;
        rel_req  = req_valid && is_ctrl && idx == IDX_REL && req_write;
        viol_clr = req_valid && is_ctrl && idx == IDX_VIOL && req_write && req_wdata[0];
    end

    pguard_fsm #(.DID_W(DID_W), .RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .rel_req  (rel_req),
        .req_did  (req_did),
        .state    (state),
        .owner    (owner),
        .grant    (grant),
        .rel_ok   (rel_ok),
        .slv_rst  (slv_rst)
    );

    pguard_viol #(.DID_W(DID_W), .ADDR_W(ADDR_W)) u_viol (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (viol_set),
        .set_did  (req_did),
        .set_addr (req_addr),
        .clr      (viol_clr),
        .irq      (irq_viol),
        .cap_did  (cap_did),
        .cap_addr (cap_addr)
    );

    // slave side: forwarded in the request cycle
    always_comb begin
        slv_valid = data_ok;
        slv_write = req_write;
        slv_addr  = req_addr[ADDR_W-2:0];
        slv_wdata = req_wdata;
    end

    // response contents
    always_comb begin
        rdata_n = '0;
        err_n   = 1'b0;
        if (is_ctrl) begin
            unique case (idx)
                IDX_LOCK:   rdata_n[0] = grant;
                IDX_REL:    err_n = req_write && !rel_ok;
                IDX_STATUS: begin
                    rdata_n[1:0]            = state;
                    rdata_n[FLD_LO +: DID_W] = owner;
                end
                IDX_VIOL: begin
                    rdata_n[0]              = irq_viol;
                    rdata_n[FLD_LO +: DID_W] = cap_did;
                end
                IDX_VADDR:  rdata_n[ADDR_W-1:0] = cap_addr;
                default:    rdata_n = '0;
            endcase
            if (req_write) rdata_n = '0;
        end else begin
            err_n = !data_ok;
            if (data_ok && !req_write) rdata_n = slv_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && err_n;
            rsp_rdata <= req_valid ? rdata_n : '0;
        end
    end

    p_fwd_owner_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slv_valid |-> (state == ST_OWNED && req_did == owner && !slv_rst));

    p_blocked_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_ctrl && !slv_valid) |=> (rsp_err && rsp_rdata == '0 && irq_viol));

    p_release_owner_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && state == ST_OWNED && req_did != owner) |=> state == ST_OWNED);

endmodule

// File: tb/sim_pguard_top.sv
`timescale 1ns/1ps
module sim_pguard_top;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int DID_W  = 4;
    localparam int RSTC   = 4;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [3:0]  did;
        logic [31:0] wdata;
        logic        err;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h802, 4'd1, 32'h0,    1'b0, 32'h0},     // R1 status free
        '{1'b0, 12'h800, 4'd3, 32'h0,    1'b0, 32'h1},     // R2 lock granted
        '{1'b0, 12'h802, 4'd1, 32'h0,    1'b0, 32'h301},   // R2 owner 3
        '{1'b0, 12'h800, 4'd5, 32'h0,    1'b0, 32'h0},     // R3 busy
        '{1'b1, 12'h005, 4'd3, 32'hA5A5, 1'b0, 32'h0},     // R4 owner write
        '{1'b0, 12'h005, 4'd3, 32'h0,    1'b0, 32'hA5A5},  // R4 owner read
        '{1'b0, 12'h005, 4'd5, 32'h0,    1'b1, 32'h0},     // R5 blocked
        '{1'b0, 12'h803, 4'd1, 32'h0,    1'b0, 32'h501},   // R7 first offender
        '{1'b0, 12'h007, 4'd6, 32'h0,    1'b1, 32'h0},     // R5 second offender
        '{1'b0, 12'h804, 4'd1, 32'h0,    1'b0, 32'h5},     // R7 address kept
        '{1'b1, 12'h803, 4'd1, 32'h0,    1'b0, 32'h0},     // R6 write zero
        '{1'b0, 12'h803, 4'd1, 32'h0,    1'b0, 32'h501},   // R6 still pending
        '{1'b1, 12'h803, 4'd1, 32'h1,    1'b0, 32'h0},     // R6 clear
        '{1'b0, 12'h803, 4'd1, 32'h0,    1'b0, 32'h500},   // R6 cleared, R7 field kept
        '{1'b1, 12'h801, 4'd5, 32'h0,    1'b1, 32'h0},     // R8 foreign release
        '{1'b0, 12'h802, 4'd1, 32'h0,    1'b0, 32'h301}    // R8 unchanged
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DID_W-1:0]  req_did = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              slv_valid, slv_write, slv_rst, irq_viol;
    logic [ADDR_W-2:0] slv_addr;
    logic [DATA_W-1:0] slv_wdata, slv_rdata;

    logic [DATA_W-1:0] mem [16];
    int n_chk = 0;
    int n_fail = 0;
    int rst_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pguard_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DID_W(DID_W), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_did(req_did), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .slv_valid(slv_valid), .slv_write(slv_write), .slv_addr(slv_addr),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_rst(slv_rst),
        .irq_viol(irq_viol)
    );

    // slave model: combinational read, wiped by its reset
    assign slv_rdata = mem[slv_addr[3:0]];
    always @(posedge clk) begin
        if (slv_rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if (slv_valid && slv_write) begin
            mem[slv_addr[3:0]] <= slv_wdata;
        end
    end

    always @(negedge clk) if (slv_rst) rst_seen++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(string req, logic wr, logic [11:0] addr, logic [3:0] did,
                        logic [31:0] wdata, logic err, logic [31:0] rdata);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_did = did; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(req, {30'b0, rsp_valid, rsp_err}, {30'b0, 1'b1, err});
        chk(req, rsp_rdata, rdata);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset outputs
        chk("R1", {29'b0, irq_viol, slv_rst, slv_valid}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            xfer($sformatf("table %0d", v), TBL[v].wr, TBL[v].addr, TBL[v].did,
                 TBL[v].wdata, TBL[v].err, TBL[v].rdata);
        end

        // R8 owner release, R9 reset window
        rst_seen = 0;
        xfer("R8", 1'b1, 12'h801, 4'd3, 32'h0, 1'b0, 32'h0);
        xfer("R9", 1'b0, 12'h802, 4'd1, 32'h0, 1'b0, 32'h2);
        xfer("R3", 1'b0, 12'h800, 4'd3, 32'h0, 1'b0, 32'h0);
        idle(6);
        chk("R9", rst_seen, RSTC);
        chk("R9", {31'b0, slv_rst}, 32'h0);
        xfer("R9", 1'b0, 12'h802, 4'd1, 32'h0, 1'b0, 32'h0);

        // R5 access while free
        xfer("R5", 1'b0, 12'h001, 4'd2, 32'h0, 1'b1, 32'h0);
        chk("R5", {31'b0, irq_viol}, 32'h1);
        xfer("R6", 1'b1, 12'h803, 4'd1, 32'h1, 1'b0, 32'h0);
        chk("R6", {31'b0, irq_viol}, 32'h0);

        // R11 new domain, wiped slave, normal access
        xfer("R11", 1'b0, 12'h800, 4'd9, 32'h0, 1'b0, 32'h1);
        xfer("R11", 1'b0, 12'h005, 4'd9, 32'h0, 1'b0, 32'h0);
        xfer("R11", 1'b1, 12'h005, 4'd9, 32'h1234, 1'b0, 32'h0);
        xfer("R11", 1'b0, 12'h005, 4'd9, 32'h0, 1'b0, 32'h1234);

        // R10 same domain release and relock still resets
        rst_seen = 0;
        xfer("R10", 1'b1, 12'h801, 4'd9, 32'h0, 1'b0, 32'h0);
        idle(6);
        chk("R10", rst_seen, RSTC);
        xfer("R10", 1'b0, 12'h800, 4'd9, 32'h0, 1'b0, 32'h1);
        xfer("R10", 1'b0, 12'h005, 4'd9, 32'h0, 1'b0, 32'h0);
        xfer("R2", 1'b0, 12'h802, 4'd1, 32'h0, 1'b0, 32'h901);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule